// File: doc/BRIEF.md
# Time-Shared Four-Tap FIR Filter

This block computes a four-tap finite impulse response filter with one multiplier and one adder, both shared across all four taps. One input sample is taken every four clock cycles. In the four cycles that follow an accepted sample, a tap counter steps through the taps in turn. Each cycle it picks one coefficient and one sample of the right age, multiplies them and adds the product into a running sum. When the last tap has been added, the full sum is written to the output register and flagged valid for one cycle.

Coefficients are written through a small addressed write port. The upstream side offers samples with `in_valid` and sees `in_ready` high only while the filter is idle at its first tap. The sum is kept at full precision, so no product or partial sum can overflow.

Top module: `fir4_folded`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the tap counter, the sample history, the accumulator and the output: after reset `in_ready` is 1, `out_valid` is 0, `out_data` is 0, and older samples count as zero in the next outputs. Coefficient registers keep their values through reset.
- R2: `in_ready` is 1 only while the filter is idle. A sample is accepted in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for exactly the three following cycles and 1 again in the fourth.
- R3: `in_valid` in a cycle where `in_ready` is 0 is ignored: the sample does not enter the history and does not change any later output.
- R4: For a sample accepted in cycle t, `out_valid` is 1 in cycle t+4 and only there. Each pulse lasts one cycle.
- R5: With samples x[n] (newest) back to x[n-3], the result is c0*x[n] + c1*x[n-1] + c2*x[n-2] + c3*x[n-3]. It is computed on 16-bit two's-complement operands and given as a 34-bit two's-complement value with no loss, including the case where every operand is -32768.
- R6: `out_data` keeps its last result in every cycle where `out_valid` is 0.
- R7: A write with `coef_we` = 1 stores `coef_wdata` into coefficient k = `coef_addr`. Coefficient k multiplies the sample that is k samples old (k = 0 is the sample just accepted). A write made while the filter is idle is used by every sample accepted afterwards.
- R8: Idle cycles between samples do not insert zeros into the history. The next result uses the last three accepted samples, however long the gap was.
- R9: With `in_valid` held at 1, the filter accepts exactly one sample every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 2 | Tap index of the coefficient written |
| coef_wdata | input | 16 | Signed coefficient value |
| in_valid | input | 1 | Sample offered |
| in_sample | input | 16 | Signed input sample |
| in_ready | output | 1 | Filter idle, able to take a sample this cycle |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 34 | Signed filter result, held between pulses |

## Verification
The checks assume that coefficient writes land only while the filter is idle. A write in the middle of a period would split one result across old and new coefficients, and neither the checker nor the model defines that case. The stimulus writes coefficients only between periods, after the last result has come out. It still holds `in_valid` high across busy cycles, with samples that differ, to show that they are dropped. The checker takes the reset input as synchronous and relies on it being high at the first clock edge. The bench raises it from time zero.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  // The tap count is fixed by the folding schedule; the index width follows it.
  localparam int FIR_TAPS  = 4;
  localparam int TAP_IDX_W = $clog2(FIR_TAPS);

  typedef logic [TAP_IDX_W-1:0] tap_idx_t;

  localparam tap_idx_t TAP_FIRST = '0;
  localparam tap_idx_t TAP_LAST  = tap_idx_t'(FIR_TAPS - 1);

endpackage

// File: rtl/fir4_tap_seq.sv
module fir4_tap_seq
  import fir4_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  output logic     in_ready,
  output logic     accept,
  output logic     tap_active,
  output logic     tap_last,
  output tap_idx_t tap_idx
);

  tap_idx_t cnt_q;

  // The counter waits at the first tap until a sample arrives, then runs
  // through the remaining taps without stopping.
  assign in_ready   = (cnt_q == TAP_FIRST);
  assign accept     = in_ready & in_valid;
  assign tap_active = accept | (cnt_q != TAP_FIRST);
  assign tap_last   = (cnt_q == TAP_LAST);
  assign tap_idx    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= TAP_FIRST;
    end else if (tap_active) begin
      cnt_q <= (cnt_q == TAP_LAST) ? TAP_FIRST : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/fir4_delay_line.sv
module fir4_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_en,
  input  logic [DATA_W-1:0]       din,
  output logic [DEPTH*DATA_W-1:0] hist_flat
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  // Slot k holds the sample accepted k acceptances ago.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q[0] <= '0;
    end else if (shift_en) begin
      slot_q[0] <= din;
    end
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[k] <= '0;
      end else if (shift_en) begin
        slot_q[k] <= slot_q[k-1];
      end
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_flat
    assign hist_flat[k*DATA_W +: DATA_W] = slot_q[k];
  end

endmodule

// File: rtl/fir4_coef_bank.sv
module fir4_coef_bank
  import fir4_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int DEPTH  = FIR_TAPS
) (
  input  logic              clk,
  input  logic              we,
  input  tap_idx_t          waddr,
  input  logic [COEF_W-1:0] wdata,
  input  tap_idx_t          raddr,
  output logic [COEF_W-1:0] rdata
);

  logic [COEF_W-1:0] coef_q [DEPTH];

  // Coefficients are configuration: they are not cleared by reset.
  for (genvar k = 0; k < DEPTH; k++) begin : g_coef
    always_ff @(posedge clk) begin
      if (we && (waddr == tap_idx_t'(k))) begin
        coef_q[k] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = coef_q[raddr];
  end

endmodule

// File: rtl/fir4_mac.sv
module fir4_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 34
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_en,
  input  logic                     first_tap,
  input  logic                     last_tap,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic                     res_valid,
  output logic signed [ACC_W-1:0]  res_data
);

  localparam int PROD_W = DATA_W + COEF_W;

  // Full-precision signed product, sign-extended to the accumulator width.
  function automatic logic signed [ACC_W-1:0] tap_product(
    input logic signed [DATA_W-1:0] x,
    input logic signed [COEF_W-1:0] c
  );
    logic signed [PROD_W-1:0] p;
    p = x * c;
    return ACC_W'(p);
  endfunction

  // The first tap starts a new sum; the others add onto the running sum.
  function automatic logic signed [ACC_W-1:0] accumulate(
    input logic                    start,
    input logic signed [ACC_W-1:0] running,
    input logic signed [ACC_W-1:0] prod
  );
    return start ? prod : running + prod;
  endfunction

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] prod_w;
  logic signed [ACC_W-1:0] sum_w;

  assign prod_w = tap_product(sample, coef);
  assign sum_w  = accumulate(first_tap, acc_q, prod_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (step_en) begin
        acc_q <= sum_w;
        if (last_tap) begin
          res_data  <= sum_w;
          res_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fir4_folded.sv
module fir4_folded
  import fir4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 34
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 coef_we,
  input  logic [TAP_IDX_W-1:0] coef_addr,
  input  logic [COEF_W-1:0]    coef_wdata,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_sample,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [ACC_W-1:0]     out_data
);

  localparam int HIST_W = FIR_TAPS * DATA_W;

  // Named internal events, also observed by the bound checker.
  logic              accept;
  logic              tap_active;
  logic              tap_last;
  tap_idx_t          tap_idx;
  logic [HIST_W-1:0] hist_flat;
  logic [DATA_W-1:0] hist_arr [FIR_TAPS];
  logic [DATA_W-1:0] sample_sel;
  logic [COEF_W-1:0] coef_sel;
  logic              first_tap;
  logic signed [ACC_W-1:0] res_data;

  fir4_tap_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .accept     (accept),
    .tap_active (tap_active),
    .tap_last   (tap_last),
    .tap_idx    (tap_idx)
  );

  fir4_delay_line #(
    .DATA_W (DATA_W),
    .DEPTH  (FIR_TAPS)
  ) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (accept),
    .din       (in_sample),
    .hist_flat (hist_flat)
  );

  fir4_coef_bank #(
    .COEF_W (COEF_W),
    .DEPTH  (FIR_TAPS)
  ) u_coef (
    .clk   (clk),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_wdata),
    .raddr (tap_idx),
    .rdata (coef_sel)
  );

  for (genvar k = 0; k < FIR_TAPS; k++) begin : g_unpack
    assign hist_arr[k] = hist_flat[k*DATA_W +: DATA_W];
  end

  // Tap 0 runs in the accepting cycle, so it takes the incoming sample.
  // Later taps read the history, which has shifted by then: slot k is
  // exactly k samples older than the newest one.
  assign first_tap  = (tap_idx == TAP_FIRST);
  assign sample_sel = first_tap ? in_sample : hist_arr[tap_idx];

  fir4_mac #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W)
  ) u_mac (
    .clk       (clk),
    .rst       (rst),
    .step_en   (tap_active),
    .first_tap (first_tap),
    .last_tap  (tap_last),
    .sample    (sample_sel),
    .coef      (coef_sel),
    .res_valid (out_valid),
    .res_data  (res_data)
  );

  assign out_data = res_data;

endmodule

// File: rtl/fir4_checks.sv
module fir4_checks
  import fir4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 34
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_ready,
  input logic                         out_valid,
  input logic [ACC_W-1:0]             out_data,
  input logic                         accept,
  input logic                         tap_last,
  input logic [FIR_TAPS*DATA_W-1:0]   hist_flat
);

  // R1: the cycle after reset shows the idle state with a cleared output.
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid && out_data == '0));

  // R2, R9: busy for exactly three cycles after an accepted sample.
  a_r2_busy_window: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready ##1 !in_ready ##1 !in_ready ##1 in_ready);

  // R3: the history moves only when a sample is accepted.
  a_r3_hist_frozen: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(hist_flat));

  // R4: the result follows four cycles after acceptance.
  a_r4_result_timing: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##4 out_valid);

  // R4: the valid flag is a single-cycle pulse.
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4: a pulse is always preceded by the last tap of a period.
  a_r4_pulse_after_last_tap: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tap_last));

  // R6: the result holds between pulses.
  a_r6_hold_output: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

endmodule

bind fir4_folded fir4_checks #(
  .DATA_W (DATA_W),
  .ACC_W  (ACC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .accept    (accept),
  .tap_last  (tap_last),
  .hist_flat (hist_flat)
);

// File: tb/sim_fir4_folded.sv
module sim_fir4_folded;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coef_we = 1'b0;
  logic [1:0]  coef_addr = '0;
  logic [15:0] coef_wdata = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        in_ready;
  logic        out_valid;
  logic [33:0] out_data;

  fir4_folded u0 (
    .clk        (clk),
    .rst        (rst),
    .coef_we    (coef_we),
    .coef_addr  (coef_addr),
    .coef_wdata (coef_wdata),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench-side model of the filter, kept as plain integers.
  longint m_coef [4];
  longint m_hist [4];
  int     m_cnt;
  int     m_due;
  longint exp_y;
  longint last_y;
  int     cyc;
  int     n_cmp;
  int     n_bad;
  bit     done;
  logic [15:0] lfsr;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 4; k++) m_hist[k] = 0;
    m_cnt  = 0;
    m_due  = -1;
    last_y = 0;
  endtask

  // Checks for the current cycle, sampled at the falling edge.
  task automatic cycle_chk(input string tag);
    chk(in_ready == (m_cnt == 0), {tag, " R2 in_ready"}, longint'(in_ready), longint'(m_cnt == 0));
    if (cyc == m_due) begin
      chk(out_valid == 1'b1, {tag, " R4 out_valid pulse"}, longint'(out_valid), 1);
      chk($signed(out_data) == exp_y, {tag, " R5 out_data"}, longint'($signed(out_data)), exp_y);
      last_y = exp_y;
    end else begin
      chk(out_valid == 1'b0, {tag, " R4 no pulse"}, longint'(out_valid), 0);
      chk($signed(out_data) == last_y, {tag, " R6 held out_data"}, longint'($signed(out_data)), last_y);
    end
  endtask

  // One clock cycle: check, drive, advance the model, wait for the next fall.
  task automatic step(input bit v, input logic [15:0] x, input bit we,
                      input logic [1:0] wa, input logic [15:0] wd, input string tag);
    cycle_chk(tag);
    in_valid   = v;
    in_sample  = x;
    coef_we    = we;
    coef_addr  = wa;
    coef_wdata = wd;
    if (v && m_cnt == 0) begin
      for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = longint'($signed(x));
      exp_y = 0;
      for (int k = 0; k < 4; k++) exp_y += m_coef[k] * m_hist[k];
      m_due = cyc + 4;
      m_cnt = 1;
    end else if (m_cnt != 0) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    if (we) m_coef[wa] = longint'($signed(wd));
    @(posedge clk);
    @(negedge clk);
    cyc++;
    in_valid = 1'b0;
    coef_we  = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, 2'd0, 16'h0, tag);
  endtask

  task automatic feed(input logic [15:0] x, input string tag);
    step(1'b1, x, 1'b0, 2'd0, 16'h0, tag);
    idle(3, tag);
  endtask

  task automatic load_coefs(input logic [15:0] c0, input logic [15:0] c1,
                            input logic [15:0] c2, input logic [15:0] c3);
    step(1'b0, 16'h0, 1'b1, 2'd0, c0, "R7");
    step(1'b0, 16'h0, 1'b1, 2'd1, c1, "R7");
    step(1'b0, 16'h0, 1'b1, 2'd2, c2, "R7");
    step(1'b0, 16'h0, 1'b1, 2'd3, c3, "R7");
  endtask

  task automatic do_reset();
    rst      = 1'b1;
    in_valid = 1'b0;
    coef_we  = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    cyc += 2;
    rst = 1'b0;
    model_clear();
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(out_data == '0, "R1 out_data after reset", longint'($signed(out_data)), 0);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    cyc   = 0;
    done  = 1'b0;
    for (int k = 0; k < 4; k++) m_coef[k] = 0;
    model_clear();
    @(negedge clk);
    do_reset();

    // R7: distinct coefficients; an impulse walks through each tap in order.
    load_coefs(16'd1, 16'd10, 16'd100, 16'd1000);
    feed(16'd1, "R7 impulse");
    for (int i = 0; i < 4; i++) feed(16'd0, "R7 impulse tail");

    // R9, R3: in_valid held high, a new value every cycle; busy-cycle values dropped.
    for (int i = 0; i < 24; i++) step(1'b1, 16'(i * 37 + 5), 1'b0, 2'd0, 16'h0, "R3 R9 streaming");
    idle(4, "R9 drain");

    // R8: long gaps between samples keep the history.
    feed(16'd7, "R8 gap");
    idle(9, "R8 gap");
    feed(16'hFFF9, "R8 gap");
    idle(5, "R8 gap");
    feed(16'd3, "R8 gap");

    // R5: extreme operands, full 34-bit range.
    load_coefs(16'h8000, 16'h8000, 16'h8000, 16'h8000);
    for (int i = 0; i < 4; i++) feed(16'h8000, "R5 max positive");
    load_coefs(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF);
    for (int i = 0; i < 4; i++) feed(16'h8000, "R5 max negative");

    // R1: reset in the middle of a period clears history, keeps coefficients.
    load_coefs(16'd2, 16'hFFFD, 16'd5, 16'd11);
    feed(16'd100, "R1 pre-reset");
    step(1'b1, 16'd55, 1'b0, 2'd0, 16'h0, "R1 pre-reset");
    step(1'b0, 16'd0, 1'b0, 2'd0, 16'h0, "R1 pre-reset");
    do_reset();
    for (int i = 0; i < 4; i++) feed(16'(i + 1), "R1 post-reset");

    // R5, R3, R8: pseudo-random sweep with random coefficient sets and gaps.
    lfsr = 16'hACE1;
    for (int blk = 0; blk < 6; blk++) begin
      for (int k = 0; k < 4; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(1'b0, 16'h0, 1'b1, 2'(k), lfsr, "R7 sweep");
      end
      for (int i = 0; i < 20; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[3], lfsr, 1'b0, 2'd0, 16'h0, "R3 R5 sweep");
      end
      idle(4, "R5 sweep drain");
    end

    idle(2, "final");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule